// File: doc/BRIEF.md
# Two-Wire Nibble Configuration Register Receiver

This block receives write-only configuration traffic from a host processor over a two-wire serial bus (one clock line, one data line) and keeps a bank of sixteen 4-bit configuration registers. Both bus lines are brought into a fast system clock domain: each line passes through a two-stage synchroniser and a spike filter, and START, STOP and bus-clock rising edges are found on the filtered lines.

A transfer opens with a START, carries an 8-bit device address and then a single command byte, and is closed by a STOP. The high nibble of the command byte selects one of the sixteen registers and the low nibble is the value stored in it. A mode input switches the outputs to a fixed set of preset values. While that input is high the bus is not listened to and the stored registers keep their contents.

Top module: `nib_cfg_regs`

## Requirements
- R1: After a synchronous reset, with preset mode low, every register output is zero.
- R2: A START is a fall of the data line while the bus clock is high; a STOP is a rise of the data line while the bus clock is high. Data bits are taken on bus-clock rising edges.
- R3: The device address is taken MSB first on bus-clock pulses 1 to 8 and compared on pulse 9. Only address 0xB2 is accepted. The data line level on pulse 9 has no effect.
- R4: When the address does not match, nothing in the rest of that transfer changes any register.
- R5: The command byte is taken MSB first on pulses 10 to 17. Bits 7:4 select register k, and bits 3:0 become its value. Register k appears on cfg_nibbles[4k+3:4k].
- R6: The write happens on the rising edge of pulse 18, and the register output shows the new value one system cycle after the internal strobe. The write does not wait for the STOP, and the data level on pulse 18 has no effect.
- R7: A START that arrives in the middle of a transfer abandons that transfer and begins address reception again.
- R8: While preset_mode is high, register k outputs the preset value ~k (bitwise inverse of its 4-bit index). Bus traffic during that time leaves the stored registers unchanged, which shows once preset_mode returns low.
- R9: A pulse on either bus line that lasts fewer than GLITCH_CYC system cycles is ignored. This holds for extra bus-clock pulses and for false START or STOP spikes on the data line.
- R10: A write changes only the selected register. Without a write, the outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bus clock line, asynchronous |
| bus_data | input | 1 | Serial bus data line, asynchronous |
| preset_mode | input | 1 | High selects the preset outputs and ignores the bus |
| cfg_nibbles | output | 64 | Sixteen 4-bit register outputs, register k at bits 4k+3:4k |

## Verification
The bench injects spikes one system cycle shorter than the filter window on the bus clock during the low phase, and on the data line during the high phase. A filter that is one cycle too eager would count an extra bit or see a false START or STOP, and the command would land in the wrong register. The bench also sends addresses that differ from 0xB2 in the MSB and in the LSB, and varies the data level on pulses 9 and 18. A decoder that is off by one pulse, or that does not ignore those pulses, would store shifted or wrong nibbles. A repeated START is placed partway through the address and partway through the command, which catches a receiver that keeps its stale bit count. The register bank is read back before the STOP to show that the write does not depend on STOP. Preset mode is toggled around a valid write to show that the stored bank is not disturbed.

// File: rtl/nbus_pkg.sv
package nbus_pkg;

    localparam int NIB_W  = 4;
    localparam int NREG   = 16;
    localparam int BYTE_W = 8;
    localparam int PULSE_W = 5;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_CMD,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic clk_rise;
    } bus_evt_t;

    typedef struct packed {
        logic [NIB_W-1:0] idx;
        logic [NIB_W-1:0] data;
    } cmd_t;

    function automatic logic [NIB_W-1:0] preset_nibble(input int k);
        logic [NIB_W-1:0] kk;
        kk = k[NIB_W-1:0];
        return ~kk;
    endfunction

endpackage

// File: rtl/nbus_deglitch.sv
module nbus_deglitch #(
    parameter int   HOLD = 4,
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(HOLD + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= INIT;
            s2 <= INIT;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    // The filtered level moves only after the synchronised input has
    // disagreed with it for HOLD consecutive cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            clean <= INIT;
            cnt   <= '0;
        end else if (s2 == clean) begin
            cnt <= '0;
        end else if (cnt == CW'(HOLD - 1)) begin
            clean <= s2;
            cnt   <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/nbus_events.sv
module nbus_events
    import nbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_c,
    input  logic     sda_c,
    output bus_evt_t evt
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_c;
            sda_p <= sda_c;
        end
    end

    always_comb begin
        evt.start    = scl_p & scl_c & sda_p & ~sda_c;
        evt.stop     = scl_p & scl_c & ~sda_p & sda_c;
        evt.clk_rise = ~scl_p & scl_c;
    end
endmodule

// File: rtl/nbus_rx.sv
module nbus_rx
    import nbus_pkg::*;
#(
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'hB2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  bus_evt_t evt,
    input  logic     sda_c,
    output logic     wr_en,
    output cmd_t     wr_cmd
);
    localparam logic [PULSE_W-1:0] LAST_ADDR_BIT = PULSE_W'(BYTE_W - 1);
    localparam logic [PULSE_W-1:0] ADDR_STROBE   = PULSE_W'(BYTE_W);
    localparam logic [PULSE_W-1:0] LAST_CMD_BIT  = PULSE_W'(2 * BYTE_W);
    localparam logic [PULSE_W-1:0] WRITE_STROBE  = PULSE_W'(2 * BYTE_W + 1);

    rx_state_e          state;
    logic [PULSE_W-1:0] pulses;   // pulses seen so far in this transfer
    logic [BYTE_W-1:0]  shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            pulses <= '0;
            shreg  <= '0;
            wr_en  <= 1'b0;
            wr_cmd <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else if (evt.start) begin
                state  <= RX_ADDR;
                pulses <= '0;
                shreg  <= '0;
            end else if (evt.stop) begin
                state <= RX_IDLE;
            end else if (evt.clk_rise) begin
                unique case (state)
                    RX_ADDR: begin
                        pulses <= pulses + 1'b1;
                        if (pulses <= LAST_ADDR_BIT)
                            shreg <= {shreg[BYTE_W-2:0], sda_c};
                        else if (pulses == ADDR_STROBE)
                            state <= (shreg == DEV_ADDR) ? RX_CMD : RX_IDLE;
                    end
                    RX_CMD: begin
                        pulses <= pulses + 1'b1;
                        if (pulses <= LAST_CMD_BIT) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_c};
                        end else if (pulses == WRITE_STROBE) begin
                            wr_en  <= 1'b1;
                            wr_cmd <= cmd_t'(shreg);
                            state  <= RX_HOLD;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/nbus_bank.sv
module nbus_bank
    import nbus_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  cmd_t                  wr_cmd,
    input  logic                  preset_mode,
    output logic [NREG*NIB_W-1:0] cfg_nibbles
);
    for (genvar k = 0; k < NREG; k++) begin : g_reg
        logic [NIB_W-1:0] val;

        always_ff @(posedge clk) begin
            if (rst)
                val <= '0;
            else if (wr_en && wr_cmd.idx == NIB_W'(k))
                val <= wr_cmd.data;
        end

        assign cfg_nibbles[k*NIB_W +: NIB_W] = preset_mode ? preset_nibble(k) : val;
    end
endmodule

// File: rtl/nib_cfg_regs.sv
module nib_cfg_regs
    import nbus_pkg::*;
#(
    parameter int                GLITCH_CYC = 4,
    parameter logic [BYTE_W-1:0] DEV_ADDR   = 8'hB2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_clk,
    input  logic                  bus_data,
    input  logic                  preset_mode,
    output logic [NREG*NIB_W-1:0] cfg_nibbles
);
    logic             scl_c, sda_c;
    bus_evt_t         evt;
    logic             wr_en;
    cmd_t             wr_cmd;
    logic [NIB_W-1:0] wr_idx, wr_data;

    assign wr_idx  = wr_cmd.idx;
    assign wr_data = wr_cmd.data;

    nbus_deglitch #(.HOLD(GLITCH_CYC), .INIT(1'b1)) u_scl_flt (
        .clk(clk), .rst(rst), .raw(bus_clk), .clean(scl_c)
    );

    nbus_deglitch #(.HOLD(GLITCH_CYC), .INIT(1'b1)) u_sda_flt (
        .clk(clk), .rst(rst), .raw(bus_data), .clean(sda_c)
    );

    nbus_events u_evt (
        .clk(clk), .rst(rst), .scl_c(scl_c), .sda_c(sda_c), .evt(evt)
    );

    nbus_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
        .clk(clk), .rst(rst), .enable(~preset_mode), .evt(evt),
        .sda_c(sda_c), .wr_en(wr_en), .wr_cmd(wr_cmd)
    );

    nbus_bank u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .preset_mode(preset_mode), .cfg_nibbles(cfg_nibbles)
    );
endmodule

// File: rtl/nib_cfg_regs_chk.sv
module nib_cfg_regs_chk
    import nbus_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  preset_mode,
    input logic                  wr_en,
    input logic [NIB_W-1:0]      wr_idx,
    input logic [NIB_W-1:0]      wr_data,
    input logic [NREG*NIB_W-1:0] cfg_nibbles
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !preset_mode) |-> (cfg_nibbles == '0));

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (preset_mode || cfg_nibbles[$past(wr_idx)*NIB_W +: NIB_W] == $past(wr_data)));

    // R8
    preset_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        $past(preset_mode) |-> !wr_en);

    // R10
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !preset_mode) |=> (preset_mode || $stable(cfg_nibbles)));
endmodule

bind nib_cfg_regs nib_cfg_regs_chk u_chk (
    .clk(clk),
    .rst(rst),
    .preset_mode(preset_mode),
    .wr_en(wr_en),
    .wr_idx(wr_idx),
    .wr_data(wr_data),
    .cfg_nibbles(cfg_nibbles)
);

// File: tb/tb_nib_cfg_regs.sv
module tb_nib_cfg_regs;

    localparam int GL_CYC = 4;
    localparam int Q      = 20;
    localparam int NV     = 10;

    // {pulse-9 data level, address, command}
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'hB2, 8'h35},
        {1'b1, 8'hB2, 8'hA9},
        {1'b0, 8'hB2, 8'hF0},
        {1'b1, 8'hB2, 8'h0F},
        {1'b0, 8'h32, 8'h17},
        {1'b0, 8'hB3, 8'h27},
        {1'b1, 8'hB2, 8'h3C},
        {1'b0, 8'hB2, 8'h56},
        {1'b0, 8'h59, 8'h66},
        {1'b1, 8'hB2, 8'h7E}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda = 1'b1;
    logic        pmode = 1'b0;
    logic [63:0] cfg;

    int   n_total = 0;
    int   n_fail  = 0;
    logic done    = 1'b0;
    logic [3:0] expv [16];

    always #10 clk = ~clk;

    nib_cfg_regs #(.GLITCH_CYC(GL_CYC), .DEV_ADDR(8'hB2)) dut (
        .clk(clk), .rst(rst), .bus_clk(scl), .bus_data(sda),
        .preset_mode(pmode), .cfg_nibbles(cfg)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int k = 0; k < 16; k++) f[k*4 +: 4] = expv[k];
        return f;
    endfunction

    function automatic logic [63:0] preset_flat();
        logic [63:0] f;
        for (int k = 0; k < 16; k++) f[k*4 +: 4] = ~(4'(k));
        return f;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda = 1'b1; wt(Q);
        scl = 1'b1; wt(Q);
        sda = 1'b0; wt(Q);
        scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        sda = 1'b0; wt(Q);
        scl = 1'b1; wt(Q);
        sda = 1'b1; wt(Q);
    endtask

    // gm: 0 clean, 1 short bus-clock spike in low phase, 2 short data spike in high phase
    task automatic bus_bit(input logic b, input int gm);
        sda = b; wt(Q);
        scl = 1'b1;
        if (gm == 2) begin
            wt(8);
            sda = ~b; wt(GL_CYC - 1);
            sda = b;  wt(Q - 8 - (GL_CYC - 1));
        end else begin
            wt(Q);
        end
        scl = 1'b0; wt(Q);
        if (gm == 1) begin
            scl = 1'b1; wt(GL_CYC - 1);
            scl = 1'b0; wt(Q);
        end
    endtask

    task automatic frame(input logic [7:0] addr, input logic [7:0] cmd,
                         input logic p9, input logic p18, input int gm, input bit with_stop);
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(addr[i], gm);
        bus_bit(p9, gm);
        for (int i = 7; i >= 0; i--) bus_bit(cmd[i], gm);
        bus_bit(p18, gm);
        if (with_stop) bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) expv[k] = 4'h0;
        wt(6);
        rst = 1'b0;
        wt(2);
        // R1: reset state
        check(cfg, 64'h0, "R1 reset");

        // Table-driven transfers: R2 R3 R4 R5 R10
        for (int v = 0; v < NV; v++) begin
            logic       p9;
            logic [7:0] a, c;
            {p9, a, c} = VEC[v];
            frame(a, c, p9, 1'b0, 0, 1'b1);
            wt(10);
            if (a == 8'hB2) begin
                expv[c[7:4]] = c[3:0];
                check(cfg, model_flat(), "R2 R3 R5 R10 write");
            end else begin
                check(cfg, model_flat(), "R4 mismatched address");
            end
        end

        // R6: value visible after pulse 18, before any STOP; pulse-18 level ignored
        frame(8'hB2, 8'hC4, 1'b0, 1'b1, 0, 1'b0);
        wt(4);
        expv[12] = 4'h4;
        check(cfg, model_flat(), "R6 write before STOP");
        bus_stop();
        wt(10);
        check(cfg, model_flat(), "R6 after STOP");

        // R7: restart in the middle of the command byte
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(1'(8'hB2 >> i), 0);
        bus_bit(1'b0, 0);
        bus_bit(1'b1, 0); bus_bit(1'b0, 0); bus_bit(1'b1, 0);
        frame(8'hB2, 8'h94, 1'b0, 1'b0, 0, 1'b1);
        wt(10);
        expv[9] = 4'h4;
        check(cfg, model_flat(), "R7 restart in command");

        // R7: restart in the middle of the address
        bus_start();
        bus_bit(1'b1, 0); bus_bit(1'b0, 0); bus_bit(1'b1, 0); bus_bit(1'b1, 0);
        frame(8'hB2, 8'h8D, 1'b1, 1'b0, 0, 1'b1);
        wt(10);
        expv[8] = 4'hD;
        check(cfg, model_flat(), "R7 restart in address");

        // R9: short spikes on the bus clock
        frame(8'hB2, 8'h2B, 1'b0, 1'b0, 1, 1'b1);
        wt(10);
        expv[2] = 4'hB;
        check(cfg, model_flat(), "R9 bus clock spikes");

        // R9: short data spikes while the bus clock is high (false START/STOP)
        frame(8'hB2, 8'hD6, 1'b1, 1'b0, 2, 1'b1);
        wt(10);
        expv[13] = 4'h6;
        check(cfg, model_flat(), "R9 data spikes");

        // R4: a good transfer still works right after a mismatch
        frame(8'hB0, 8'h41, 1'b0, 1'b0, 0, 1'b1);
        frame(8'hB2, 8'h42, 1'b0, 1'b0, 0, 1'b1);
        wt(10);
        expv[4] = 4'h2;
        check(cfg, model_flat(), "R4 recovery after mismatch");

        // R8: preset outputs, bus ignored
        pmode = 1'b1;
        wt(2);
        check(cfg, preset_flat(), "R8 preset values");
        frame(8'hB2, 8'h1A, 1'b0, 1'b0, 0, 1'b1);
        frame(8'hB2, 8'h55, 1'b0, 1'b0, 0, 1'b1);
        wt(10);
        check(cfg, preset_flat(), "R8 preset during traffic");
        pmode = 1'b0;
        wt(2);
        check(cfg, model_flat(), "R8 stored bank untouched");

        // R1: reset clears written registers
        rst = 1'b1;
        wt(3);
        rst = 1'b0;
        wt(2);
        for (int k = 0; k < 16; k++) expv[k] = 4'h0;
        check(cfg, model_flat(), "R1 reset after writes");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule